// File: doc/BRIEF.md
# Multiplexed Bus Transfer Engine

This block lets internal logic run single transfers on an external peripheral whose address and data share one 8-bit parallel bus. The caller presents an address, write data and a direction flag, then pulses `start` for one cycle. The engine then runs the whole external cycle with fixed timing: an address phase with a latch strobe, a data phase with either a read or a write strobe, and a release of chip select. When the cycle is over it pulses `done` for one cycle. After a read, the captured byte is available on `rdata`.

The shared bus is split into three signals: an output byte, an output-enable, and an input byte. A pad ring or a top-level tri-state buffer combines them onto the pins. The address setup, the strobe width and the hold after each strobe are parameters, counted in clock cycles. The caller never needs to know these timings. It waits for `done`, or it watches `busy`.

Top module: `mux_bus_engine`

## Requirements
- R1: When the engine is idle, a `start` pulse latches `addr_in`, `wdata` and `rd_not_wr` (1 = read, 0 = write). Changes on these inputs after that edge have no effect on the transfer in progress.
- R2: Address phase. For `T_SETUP` cycles after an accepted start, `cs_n` is 0, `ale` is 1, `bus_oe` is 1 and `bus_o` carries the address. For the next `T_HOLD` cycles, `ale` is 0 and the address stays driven.
- R3: Write data phase. `bus_o` carries the write data and `wr_n` is 0 for `T_STROBE` cycles. The data then stays driven with `wr_n` at 1 for `T_HOLD` more cycles. `rd_n` stays at 1 for the whole write.
- R4: Read data phase. `bus_oe` is 0 from the end of the address hold until the transfer ends. `rd_n` is 0 for `T_STROBE` cycles, followed by `T_HOLD` cycles with `rd_n` at 1. `wr_n` stays at 1 for the whole read. Whenever `bus_oe` is 0, `bus_o` reads 0.
- R5: `rdata` takes the value of `bus_i` at the clock edge that ends the last cycle with `rd_n` at 0. It holds that value until the next read captures a new one. Writes never change it.
- R6: The transfer ends with one cycle in which `cs_n` is 1, `bus_oe` is 0 and `done` is 1. `done` is never high for two cycles in a row. The full transfer lasts `T_SETUP + 2*T_HOLD + T_STROBE + 1` cycles.
- R7: `busy` is 1 from the cycle after an accepted start through the `done` cycle. A `start` pulse seen while `busy` is 1, including during the `done` cycle, is ignored.
- R8: An active-low asynchronous reset `rst_n` forces the idle state at once: `cs_n`, `rd_n` and `wr_n` at 1; `ale`, `bus_oe`, `done` and `busy` at 0; `rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transfer |
| rd_not_wr | input | 1 | Direction: 1 read, 0 write |
| addr_in | input | 8 | Peripheral address |
| wdata | input | 8 | Write data, unused for reads |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| rdata | output | 8 | Byte captured by the latest read |
| bus_o | output | 8 | Byte driven toward the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| bus_i | input | 8 | Byte sampled from the shared bus |
| ale | output | 1 | Address latch strobe, active high |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Two events can land in the same cycle: the emission of `done` and the arrival of a new `start` request. The bench pulses `start` with fresh operands exactly in the `done` cycle, and also in the middle of a transfer. It then requires the following cycle to be idle, with no chip select or latch strobe, and requires the earlier operands to have been used. A behavioural model steps through the transfer position every clock, and a peripheral model answers reads with a value derived from the latched address. Together they check every output on every cycle, including a reset applied in the middle of a transfer.

// File: rtl/mux_bus_engine.sv
module mux_bus_engine #(
  parameter int T_SETUP  = 2,
  parameter int T_STROBE = 2,
  parameter int T_HOLD   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_not_wr,
  input  logic [7:0] addr_in,
  input  logic [7:0] wdata,
  output logic       done,
  output logic       busy,
  output logic [7:0] rdata,
  output logic [7:0] bus_o,
  output logic       bus_oe,
  input  logic [7:0] bus_i,
  output logic       ale,
  output logic       cs_n,
  output logic       rd_n,
  output logic       wr_n
);
  localparam int TMAX = (T_SETUP > T_STROBE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                             : ((T_STROBE > T_HOLD) ? T_STROBE : T_HOLD);
  localparam int CW = (TMAX > 1) ? $clog2(TMAX) : 1;

  typedef enum logic [2:0] {IDLE, ADDR, AHLD, STRB, DHLD, FIN} state_t;

  state_t        st, st_nx;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          rw_q;
  logic [7:0]    a_q, d_q;
  logic          last;

  always_comb begin
    case (st)
      ADDR:    lim = CW'(T_SETUP - 1);
      STRB:    lim = CW'(T_STROBE - 1);
      default: lim = CW'(T_HOLD - 1);
    endcase
  end

  assign last = (cnt == lim);

  always_comb begin
    st_nx = st;
    case (st)
      IDLE: if (start) st_nx = ADDR;
      ADDR: if (last) st_nx = AHLD;
      AHLD: if (last) st_nx = STRB;
      STRB: if (last) st_nx = DHLD;
      DHLD: if (last) st_nx = FIN;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      rw_q  <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
      rdata <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (st != IDLE && st != FIN) cnt <= cnt + 1'b1;
      if (st == IDLE && start) begin
        rw_q <= rd_not_wr;
        a_q  <= addr_in;
        d_q  <= wdata;
      end
      if (st == STRB && last && rw_q) rdata <= bus_i;
    end
  end

  assign busy   = (st != IDLE);
  assign done   = (st == FIN);
  assign cs_n   = (st == IDLE) || (st == FIN);
  assign ale    = (st == ADDR);
  assign rd_n   = !(st == STRB && rw_q);
  assign wr_n   = !(st == STRB && !rw_q);
  assign bus_oe = (st == ADDR) || (st == AHLD) || (!rw_q && (st == STRB || st == DHLD));
  assign bus_o  = !bus_oe ? 8'h00 : ((st == ADDR || st == AHLD) ? a_q : d_q);

  // R4
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !bus_oe);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done && !busy);
  // R6
  done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n && !bus_oe);
  // R2
  latch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ale) |-> !cs_n && bus_oe);
  // R5
  rdata_src_chk: assert property (@(posedge clk) disable iff (!rst_n) (rdata != $past(rdata)) |-> $past(!rd_n));
  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy && ale);
endmodule

// File: tb/sim_mux_bus_engine.sv
module sim_mux_bus_engine;
  localparam int TS = 2, TST = 2, TH = 2;
  localparam int N = TS + 2*TH + TST + 1;

  logic clk = 0, rst_n = 0, start = 0, rd_not_wr = 0;
  logic [7:0] addr_in = 0, wdata = 0, bus_i;
  logic done, busy, bus_oe, ale, cs_n, rd_n, wr_n;
  logic [7:0] rdata, bus_o, periph_lat;

  int vec = 0, bad = 0;
  int m_busy = 0, t = 0, m_rw = 0;
  logic [7:0] m_a = 0, m_d = 0, m_rdata = 0;

  mux_bus_engine #(.T_SETUP(TS), .T_STROBE(TST), .T_HOLD(TH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_not_wr(rd_not_wr),
    .addr_in(addr_in), .wdata(wdata), .done(done), .busy(busy), .rdata(rdata),
    .bus_o(bus_o), .bus_oe(bus_oe), .bus_i(bus_i), .ale(ale), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n));

  always #10 clk = ~clk;

  initial periph_lat = 8'h00;
  always @(negedge ale) periph_lat = bus_o;
  assign bus_i = (!rd_n) ? (periph_lat ^ 8'hA5) : 8'hEE;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d act=%h exp=%h at %0t", tag, t, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e_ale, e_cs, e_rd, e_wr, e_oe, e_done, strb;
    logic [7:0] e_bus;
    strb   = m_busy && t >= TS+TH && t < TS+TH+TST;
    e_ale  = m_busy && t < TS;
    e_cs   = !(m_busy && t < N-1);
    e_rd   = !(strb && m_rw == 1);
    e_wr   = !(strb && m_rw == 0);
    e_oe   = m_busy && (t < TS+TH || (m_rw == 0 && t < N-1));
    e_done = m_busy && t == N-1;
    e_bus  = !e_oe ? 8'h00 : (t < TS+TH ? m_a : m_d);
    chk("R2 ale", {7'd0, ale}, {7'd0, e_ale});
    chk("R2 cs_n", {7'd0, cs_n}, {7'd0, e_cs});
    chk("R4 rd_n", {7'd0, rd_n}, {7'd0, e_rd});
    chk("R3 wr_n", {7'd0, wr_n}, {7'd0, e_wr});
    chk("R4 bus_oe", {7'd0, bus_oe}, {7'd0, e_oe});
    chk("R1 bus_o", bus_o, e_bus);
    chk("R6 done", {7'd0, done}, {7'd0, e_done});
    chk("R7 busy", {7'd0, busy}, {7'd0, 8'(m_busy != 0)});
    chk("R5 rdata", rdata, m_rdata);
  endtask

  task automatic step(input logic s, input logic rw, input logic [7:0] a, input logic [7:0] d);
    start = s; rd_not_wr = rw; addr_in = a; wdata = d;
    if (m_busy == 0) begin
      if (s) begin m_busy = 1; t = 0; m_rw = rw; m_a = a; m_d = d; end
    end else begin
      if (m_rw == 1 && t == TS+TH+TST-1) m_rdata = m_a ^ 8'hA5;
      if (t == N-1) m_busy = 0; else t++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic xfer(input logic rw, input logic [7:0] a, input logic [7:0] d);
    step(1, rw, a, d);
    for (int i = 0; i < N-1; i++) step(0, ~rw, ~a, ~d);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1; compare();                       // R8 reset state
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0);
    xfer(0, 8'h3C, 8'h81);               // R3 write
    step(0, 0, 0, 0);
    xfer(1, 8'h12, 8'h55);               // R4 R5 read, rdata B7
    step(1, 0, 8'hF0, 8'h0F);            // R7 start in done cycle ignored
    step(0, 0, 0, 0);
    xfer(0, 8'h77, 8'h99);               // R5 write keeps rdata
    step(0, 0, 0, 0);
    step(1, 1, 8'h5A, 8'h00);            // R7 start mid-transfer ignored
    step(0, 1, 8'h5A, 8'h00);
    step(1, 0, 8'hC3, 8'hAA);
    for (int i = 0; i < N-3; i++) step(0, 0, 8'h00, 8'h00);
    xfer(1, 8'hFF, 8'h00);               // R1 back-to-back read, inputs change
    xfer(0, 8'h00, 8'hFF);
    step(1, 1, 8'h21, 8'h00);            // R8 reset mid-transfer
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    #3 rst_n = 0;
    m_busy = 0; t = 0; m_rdata = 0;
    #1 compare();
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0);
    xfer(1, 8'h40, 8'h00);               // R5 R6 read after reset
    step(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule